// File: doc/BRIEF.md
# Serial Flash Command Register Front End

This block is the register-level entry point of a serial flash controller that supports one to eight data lanes. Software first programs six 32-bit command words, from the highest word down to the lowest, and then writes the lowest word. That last write launches the command. The block decodes the stored words into a transaction descriptor, holds that descriptor for a downstream sequencer, and records the outcome in a status word that software can read. It also raises a maskable interrupt.

There are two kinds of command. A header instruction carries the opcode, up to six address bytes and the lane codes. A header of the no-data kind is dispatched on its own. A header that announces a data phase is kept aside and does not dispatch anything. The data-sequence instruction launched next completes it with a byte count, a dummy cycle count, a data lane code, a bank and a direction, and the two are then dispatched together as one descriptor. The sequencer is modelled by a simple handshake: the descriptor stays valid until the sequencer pulses `seq_done` with a 4-bit error vector. The block reports itself busy for as long as a descriptor is outstanding.

Top module: `flashcmd_frontend`

## Requirements
- R1: After reset, the registers at 0x044, 0x100, 0x110, 0x114 and 0x230 all read 0, and `desc_valid` and `irq` are low.
- R2: A launch is a write to offset 0x000. When the type field (word 1 bits 6:0) of a launch is 0, `desc_valid` rises on the next cycle and the descriptor is filled as follows:
  - opcode from word 3 bits 23:16;
  - address bytes from word 1 bits 31:24 (byte 0), word 2 bytes 0..3 (bytes 1..4) and word 3 bits 7:0 (byte 5);
  - address byte count from word 3 bits 30:28;
  - address lane code from word 4 bits 1:0 and command lane code from word 4 bits 9:8;
  - bank from word 4 bits 14:12;
  - `desc_has_data` = 0, and the data-only fields are zero.
  
  Bit 7 of 0x100 then reads 1.
- R3: A launch of type 1 dispatches nothing. The next launch, if it has type 127, dispatches the stored header together with the data fields, with `desc_has_data` = 1:
  - byte count = {word 3 bits 15:0, word 2 bits 31:16};
  - dummy count from word 3 bits 25:20;
  - data lane code from word 4 bits 9:8;
  - bank from word 4 bits 14:12;
  - direction from word 4 bit 4 (0 = read, 1 = write).
  
  This dispatch also sets interrupt status bit 21.
- R4: A launch with type 127 that does not directly follow a type-1 launch is rejected, and so is a launch of any type other than 0, 1 or 127. A rejected launch dispatches nothing, sets the status at 0x044 to 0x0000C001, and sets interrupt status bit 22. It also sets bit 23 if bit 0 of the launching write is 1.
- R5: A `seq_done` pulse while `desc_valid` is high completes the command:
  - `desc_valid` falls and busy clears;
  - the status at 0x044 becomes bit 15 = 1, bit 14 = OR of `seq_err`, and bits 3:0 = `seq_err`;
  - interrupt status bit 23 is set if bit 0 of the dispatching launch write was 1;
  - interrupt status bit 22 is set if `seq_err` is non-zero.
- R6: Every accepted launch that is not rejected clears the status at 0x044 to 0.
- R7: A launch is ignored while busy, or while the mode field (0x230 bits 6:5) is anything other than 1. An ignored launch leaves the descriptor and the status unchanged.
- R8: The interrupt status bits at 0x110 are cleared by writing 1 to them. Writing 0 leaves a bit unchanged.
- R9: `irq` is high exactly when bit 31 of 0x114 is set and some bit among 23:21 is set in both 0x110 and 0x114.
- R10: The six command words at offsets 0x000 to 0x014 read back what was written to them. At 0x230 only bits 6:5 are kept, and at 0x114 only bits 31 and 23:21 are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 12 | Register read byte offset |
| rd_data | output | 32 | Register read data (combinational) |
| desc_valid | output | 1 | Descriptor outstanding for the sequencer |
| desc_opcode | output | 8 | Command opcode |
| desc_addr | output | 48 | Address, byte 0 in bits 7:0 |
| desc_addr_nbytes | output | 3 | Number of address bytes |
| desc_cmd_lanes | output | 2 | log2 of command lanes |
| desc_addr_lanes | output | 2 | log2 of address lanes |
| desc_data_lanes | output | 2 | log2 of data lanes |
| desc_bank | output | 3 | Chip-select bank |
| desc_has_data | output | 1 | Command has a data phase |
| desc_dir | output | 1 | 0 read, 1 write |
| desc_nbytes | output | 32 | Data byte count |
| desc_dummy | output | 6 | Dummy bit cycles |
| seq_done | input | 1 | Sequencer completion pulse |
| seq_err | input | 4 | Error causes reported with `seq_done` |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- each dispatch event makes `desc_valid` rise one cycle later;
- a completion drops it;
- a busy descriptor stays frozen until completion;
- a rejected launch never produces a descriptor;
- launches are only accepted in command mode;
- the interrupt line is never high without the global enable.

Some behaviour only the bench scenarios can show. These are the field-by-field descriptor contents, the status encodings, the pairing of header and data sequence, the interrupt status bits with their write-one-to-clear behaviour, and register readback. The bench covers them with random commands and directed cases, and checks each against expected values it computes itself.

// File: rtl/flashcmd_pkg.sv
package flashcmd_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned NUM_CMD_REGS = 6;

  localparam logic [11:0] OFF_STATUS = 12'h044;
  localparam logic [11:0] OFF_CTRLST = 12'h100;
  localparam logic [11:0] OFF_IST    = 12'h110;
  localparam logic [11:0] OFF_IEN    = 12'h114;
  localparam logic [11:0] OFF_CONFIG = 12'h230;

  localparam logic [6:0] ITYPE_HDR_NODATA = 7'd0;
  localparam logic [6:0] ITYPE_HDR_DATA   = 7'd1;
  localparam logic [6:0] ITYPE_DATASEQ    = 7'd127;

  localparam logic [1:0] MODE_CMD = 2'd1;

  localparam int unsigned IRQ_LSB   = 21;
  localparam int unsigned IRQ_NSRC  = 3;
  localparam int unsigned IRQ_GLOBAL = 31;
  localparam int unsigned BUSY_BIT  = 7;

  typedef struct packed {
    logic [7:0]  opcode;
    logic [47:0] addr;
    logic [2:0]  addr_nbytes;
    logic [1:0]  cmd_lanes;
    logic [1:0]  addr_lanes;
    logic [2:0]  bank;
  } hdr_t;

  typedef struct packed {
    logic [31:0] nbytes;
    logic [5:0]  dummy;
    logic [1:0]  data_lanes;
    logic [2:0]  bank;
    logic        dir;
  } dseq_t;

  function automatic hdr_t decode_hdr(input logic [31:0] w1, input logic [31:0] w2,
                                      input logic [31:0] w3, input logic [31:0] w4);
    hdr_t h;
    h.opcode      = w3[23:16];
    h.addr        = {w3[7:0], w2[31:24], w2[23:16], w2[15:8], w2[7:0], w1[31:24]};
    h.addr_nbytes = w3[30:28];
    h.cmd_lanes   = w4[9:8];
    h.addr_lanes  = w4[1:0];
    h.bank        = w4[14:12];
    return h;
  endfunction

  function automatic dseq_t decode_dseq(input logic [31:0] w2, input logic [31:0] w3,
                                        input logic [31:0] w4);
    dseq_t d;
    d.nbytes     = {w3[15:0], w2[31:16]};
    d.dummy      = w3[25:20];
    d.data_lanes = w4[9:8];
    d.bank       = w4[14:12];
    d.dir        = w4[4];
    return d;
  endfunction

  function automatic logic [31:0] pack_status(input logic [3:0] causes);
    return {16'd0, 1'b1, |causes, 10'd0, causes};
  endfunction
endpackage

// File: rtl/flashcmd_cmdregs.sv
module flashcmd_cmdregs #(
  parameter int unsigned NREG = 6,
  parameter int unsigned AW   = 12,
  parameter int unsigned DW   = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [DW-1:0]           wr_data,
  output logic [NREG-1:0][DW-1:0] words
);
  localparam int unsigned STRIDE = DW / 8;

  for (genvar g = 0; g < NREG; g++) begin : g_word
    logic [DW-1:0] q;
    logic          hit;
    assign hit = wr_en && (wr_addr == AW'(g * STRIDE));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= wr_data;
    end
    assign words[g] = q;
  end
endmodule

// File: rtl/flashcmd_ctrl.sv
module flashcmd_ctrl
  import flashcmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        launch,
  input  logic        launch_irq_req,
  input  logic [31:0] w1,
  input  logic [31:0] w2,
  input  logic [31:0] w3,
  input  logic [31:0] w4,
  input  logic        seq_done,
  input  logic [3:0]  seq_err,
  output hdr_t        hdr_q,
  output dseq_t       dseq_q,
  output logic        has_data_q,
  output logic        valid_q,
  output logic [31:0] status_q,
  output logic        evt_dispatch,
  output logic        evt_bad,
  output logic        evt_done,
  output logic [IRQ_NSRC-1:0] irq_set
);
  logic [6:0] itype;
  hdr_t       hdr_now;
  dseq_t      dseq_now;
  hdr_t       pend_hdr_q;
  logic       pend_q;
  logic       req_q;
  logic       evt_hdr_nd, evt_hdr_d, evt_dseq_ok;

  assign itype    = w1[6:0];
  assign hdr_now  = decode_hdr(w1, w2, w3, w4);
  assign dseq_now = decode_dseq(w2, w3, w4);

  assign evt_hdr_nd   = launch && (itype == ITYPE_HDR_NODATA);
  assign evt_hdr_d    = launch && (itype == ITYPE_HDR_DATA);
  assign evt_dseq_ok  = launch && (itype == ITYPE_DATASEQ) && pend_q;
  assign evt_bad      = launch && !(evt_hdr_nd || evt_hdr_d || evt_dseq_ok);
  assign evt_dispatch = evt_hdr_nd || evt_dseq_ok;
  assign evt_done     = seq_done && valid_q;

  // bit 0 -> trigger (21), bit 1 -> failure (22), bit 2 -> done (23)
  assign irq_set[0] = evt_dseq_ok;
  assign irq_set[1] = evt_bad || (evt_done && (seq_err != 4'd0));
  assign irq_set[2] = (evt_bad && launch_irq_req) || (evt_done && req_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q      <= '0;
      dseq_q     <= '0;
      pend_hdr_q <= '0;
      has_data_q <= 1'b0;
      pend_q     <= 1'b0;
      valid_q    <= 1'b0;
      req_q      <= 1'b0;
      status_q   <= '0;
    end else begin
      if (evt_hdr_nd) begin
        hdr_q      <= hdr_now;
        dseq_q     <= '0;
        has_data_q <= 1'b0;
      end
      if (evt_hdr_d) pend_hdr_q <= hdr_now;
      if (evt_dseq_ok) begin
        hdr_q      <= pend_hdr_q;
        dseq_q     <= dseq_now;
        has_data_q <= 1'b1;
      end
      if (launch) pend_q <= evt_hdr_d;
      if (evt_dispatch) begin
        valid_q <= 1'b1;
        req_q   <= launch_irq_req;
      end else if (evt_done) begin
        valid_q <= 1'b0;
      end
      if (evt_bad)       status_q <= pack_status(4'b0001);
      else if (launch)   status_q <= '0;
      else if (evt_done) status_q <= pack_status(seq_err);
    end
  end
endmodule

// File: rtl/flashcmd_irq.sv
module flashcmd_irq #(
  parameter int unsigned LSB  = 21,
  parameter int unsigned NSRC = 3,
  parameter int unsigned GLB  = 31
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ist_wr,
  input  logic            ien_wr,
  input  logic [31:0]     wr_data,
  input  logic [NSRC-1:0] set,
  output logic [31:0]     ist_word,
  output logic [31:0]     ien_word,
  output logic            irq
);
  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] en_q;
  logic            glb_q;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[s] <= 1'b0;
        en_q[s]   <= 1'b0;
      end else begin
        if (set[s])                           pend_q[s] <= 1'b1;
        else if (ist_wr && wr_data[LSB + s])  pend_q[s] <= 1'b0;
        if (ien_wr) en_q[s] <= wr_data[LSB + s];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      glb_q <= 1'b0;
    else if (ien_wr) glb_q <= wr_data[GLB];
  end

  always_comb begin
    ist_word = '0;
    ien_word = '0;
    ist_word[LSB +: NSRC] = pend_q;
    ien_word[LSB +: NSRC] = en_q;
    ien_word[GLB]         = glb_q;
  end

  assign irq = glb_q && |(pend_q & en_q);
endmodule

// File: rtl/flashcmd_frontend.sv
module flashcmd_frontend
  import flashcmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [11:0] wr_addr,
  input  logic [31:0] wr_data,
  input  logic [11:0] rd_addr,
  output logic [31:0] rd_data,
  output logic        desc_valid,
  output logic [7:0]  desc_opcode,
  output logic [47:0] desc_addr,
  output logic [2:0]  desc_addr_nbytes,
  output logic [1:0]  desc_cmd_lanes,
  output logic [1:0]  desc_addr_lanes,
  output logic [1:0]  desc_data_lanes,
  output logic [2:0]  desc_bank,
  output logic        desc_has_data,
  output logic        desc_dir,
  output logic [31:0] desc_nbytes,
  output logic [5:0]  desc_dummy,
  input  logic        seq_done,
  input  logic [3:0]  seq_err,
  output logic        irq
);
  localparam int unsigned WORD_IDX_W = $clog2(NUM_CMD_REGS);

  logic [NUM_CMD_REGS-1:0][REG_W-1:0] words;
  logic [1:0]  mode_q;
  logic        cmd_mode;
  logic        launch_req, launch_ok;
  hdr_t        hdr_q;
  dseq_t       dseq_q;
  logic        has_data_q, valid_q;
  logic [31:0] status_q;
  logic        evt_dispatch, evt_bad, evt_done;
  logic [IRQ_NSRC-1:0] irq_set;
  logic [31:0] ist_word, ien_word;
  logic        ist_wr, ien_wr;

  flashcmd_cmdregs #(.NREG(NUM_CMD_REGS), .AW(ADDR_W), .DW(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .words(words)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                mode_q <= 2'd0;
    else if (wr_en && wr_addr == OFF_CONFIG)   mode_q <= wr_data[6:5];
  end

  assign cmd_mode   = (mode_q == MODE_CMD);
  assign launch_req = wr_en && (wr_addr == 12'h000);
  assign launch_ok  = launch_req && cmd_mode && !valid_q;

  flashcmd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .launch(launch_ok), .launch_irq_req(wr_data[0]),
    .w1(words[1]), .w2(words[2]), .w3(words[3]), .w4(words[4]),
    .seq_done(seq_done), .seq_err(seq_err),
    .hdr_q(hdr_q), .dseq_q(dseq_q), .has_data_q(has_data_q), .valid_q(valid_q),
    .status_q(status_q), .evt_dispatch(evt_dispatch), .evt_bad(evt_bad),
    .evt_done(evt_done), .irq_set(irq_set)
  );

  assign ist_wr = wr_en && (wr_addr == OFF_IST);
  assign ien_wr = wr_en && (wr_addr == OFF_IEN);

  flashcmd_irq #(.LSB(IRQ_LSB), .NSRC(IRQ_NSRC), .GLB(IRQ_GLOBAL)) u_irq (
    .clk(clk), .rst_n(rst_n), .ist_wr(ist_wr), .ien_wr(ien_wr), .wr_data(wr_data),
    .set(irq_set), .ist_word(ist_word), .ien_word(ien_word), .irq(irq)
  );

  assign desc_valid       = valid_q;
  assign desc_opcode      = hdr_q.opcode;
  assign desc_addr        = hdr_q.addr;
  assign desc_addr_nbytes = hdr_q.addr_nbytes;
  assign desc_cmd_lanes   = hdr_q.cmd_lanes;
  assign desc_addr_lanes  = hdr_q.addr_lanes;
  assign desc_data_lanes  = dseq_q.data_lanes;
  assign desc_bank        = has_data_q ? dseq_q.bank : hdr_q.bank;
  assign desc_has_data    = has_data_q;
  assign desc_dir         = dseq_q.dir;
  assign desc_nbytes      = dseq_q.nbytes;
  assign desc_dummy       = dseq_q.dummy;

  always_comb begin
    rd_data = '0;
    if (rd_addr < 12'(NUM_CMD_REGS * 4) && rd_addr[1:0] == 2'b00) begin
      rd_data = words[rd_addr[WORD_IDX_W+1:2]];
    end else begin
      case (rd_addr)
        OFF_STATUS: rd_data = status_q;
        OFF_CTRLST: rd_data[BUSY_BIT] = valid_q;
        OFF_IST:    rd_data = ist_word;
        OFF_IEN:    rd_data = ien_word;
        OFF_CONFIG: rd_data[6:5] = mode_q;
        default:    rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/flashcmd_checker.sv
module flashcmd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       launch_ok,
  input logic       cmd_mode,
  input logic       evt_dispatch,
  input logic       evt_bad,
  input logic       evt_done,
  input logic       seq_done,
  input logic       desc_valid,
  input logic [7:0] desc_opcode,
  input logic       irq,
  input logic [31:0] ien_word
);
  a_r2_dispatch_raises_valid: assert property (@(posedge clk) disable iff (!rst_n)
    evt_dispatch |=> desc_valid);
  a_r5_done_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |=> !desc_valid);
  a_r7_busy_descriptor_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && !seq_done) |=> (desc_valid && $stable(desc_opcode)));
  a_r4_reject_no_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
    evt_bad |=> !desc_valid);
  a_r7_launch_needs_cmd_mode: assert property (@(posedge clk) disable iff (!rst_n)
    launch_ok |-> cmd_mode);
  a_r9_irq_needs_global: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ien_word[31]);
endmodule

bind flashcmd_frontend flashcmd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .launch_ok(launch_ok), .cmd_mode(cmd_mode),
  .evt_dispatch(evt_dispatch), .evt_bad(evt_bad), .evt_done(evt_done),
  .seq_done(seq_done), .desc_valid(desc_valid), .desc_opcode(desc_opcode),
  .irq(irq), .ien_word(ien_word)
);

// File: tb/flashcmd_frontend_tb_top.sv
`timescale 1ns/1ps
module flashcmd_frontend_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [11:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic        desc_valid;
  logic [7:0]  desc_opcode;
  logic [47:0] desc_addr;
  logic [2:0]  desc_addr_nbytes;
  logic [1:0]  desc_cmd_lanes, desc_addr_lanes, desc_data_lanes;
  logic [2:0]  desc_bank;
  logic        desc_has_data, desc_dir;
  logic [31:0] desc_nbytes;
  logic [5:0]  desc_dummy;
  logic        seq_done = 1'b0;
  logic [3:0]  seq_err = '0;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  flashcmd_frontend dut_i (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic finish_cmd(input logic [3:0] e);
    seq_done = 1'b1; seq_err = e;
    @(negedge clk);
    seq_done = 1'b0; seq_err = '0;
  endtask

  task automatic send(input logic [31:0] c0, input logic [31:0] c1, input logic [31:0] c2,
                      input logic [31:0] c3, input logic [31:0] c4);
    bus_wr(12'h014, 32'd0);
    bus_wr(12'h010, c4);
    bus_wr(12'h00C, c3);
    bus_wr(12'h008, c2);
    bus_wr(12'h004, c1);
    bus_wr(12'h000, c0);
  endtask

  // Encoders written from the field positions in the requirements
  function automatic logic [31:0] e_w1(input logic [6:0] t, input logic [7:0] a0);
    return {a0, 17'd0, t};
  endfunction
  function automatic logic [31:0] e_hw3(input logic [2:0] nab, input logic [7:0] op, input logic [7:0] a5);
    return {1'b0, nab, 4'd0, op, 8'd0, a5};
  endfunction
  function automatic logic [31:0] e_hw4(input logic [2:0] bk, input logic [1:0] cl, input logic [1:0] al);
    return {17'd0, bk, 2'd0, cl, 6'd0, al};
  endfunction
  function automatic logic [31:0] e_dw2(input logic [31:0] n);
    return {n[15:0], 16'd0};
  endfunction
  function automatic logic [31:0] e_dw3(input logic [31:0] n, input logic [5:0] dm);
    return {6'd0, dm, 4'd0, n[31:16]};
  endfunction
  function automatic logic [31:0] e_dw4(input logic [2:0] bk, input logic [1:0] dl, input logic dir);
    return {17'd0, bk, 2'd0, dl, 3'd0, dir, 4'd0};
  endfunction
  function automatic logic [31:0] exp_status(input logic [3:0] e);
    logic [31:0] s;
    s = '0; s[15] = 1'b1; s[14] = (e != 0); s[3:0] = e;
    return s;
  endfunction

  initial begin
    #(200000 * 8);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    bus_rd(12'h044, v); chk("R1 status", v, 0);
    bus_rd(12'h100, v); chk("R1 ctrl", v, 0);
    bus_rd(12'h110, v); chk("R1 ist", v, 0);
    bus_rd(12'h114, v); chk("R1 ien", v, 0);
    bus_rd(12'h230, v); chk("R1 config", v, 0);
    chk("R1 valid", desc_valid, 0);
    chk("R1 irq", irq, 0);

    // R7 launch ignored outside command mode; R10 readback
    send(0, e_w1(0, 8'h11), 32'h44332211, e_hw3(3'd4, 8'h9F, 8'h66), e_hw4(3'd2, 2'd1, 2'd0));
    chk("R7 mode gate", desc_valid, 0);
    bus_rd(12'h00C, v); chk("R10 word3", v, e_hw3(3'd4, 8'h9F, 8'h66));
    bus_rd(12'h008, v); chk("R10 word2", v, 32'h44332211);
    bus_wr(12'h230, 32'hFFFF_FFBF);  // bits 6:5 = 01
    bus_rd(12'h230, v); chk("R10 config mask", v, 32'h20);
    bus_wr(12'h114, 32'hFFFF_FFFF);
    bus_rd(12'h114, v); chk("R10 ien mask", v, 32'h80E0_0000);
    bus_wr(12'h114, 32'h0);

    // R2 plus R7 busy: second launch while busy ignored
    send(0, e_w1(0, 8'hA5), 32'h0403_0201, e_hw3(3'd5, 8'h0B, 8'h55), e_hw4(3'd3, 2'd3, 2'd2));
    chk("R2 valid", desc_valid, 1);
    chk("R2 opcode", desc_opcode, 8'h0B);
    chk("R2 addr", desc_addr, 48'h55_0403_0201_A5);
    bus_rd(12'h100, v); chk("R2 busy", v, 32'h80);
    bus_rd(12'h044, v); chk("R6 status cleared", v, 0);
    send(0, e_w1(0, 8'h00), 32'h0, e_hw3(3'd1, 8'hEE, 8'h00), e_hw4(3'd0, 2'd0, 2'd0));
    chk("R7 busy ignore opcode", desc_opcode, 8'h0B);
    chk("R7 busy ignore valid", desc_valid, 1);
    finish_cmd(4'd0);
    chk("R5 valid drop", desc_valid, 0);
    bus_rd(12'h044, v); chk("R5 status ok", v, 32'h8000);

    // R4 unknown type with done request, R8 partial clear, R9 gating
    send(32'h1, e_w1(7'd5, 8'h0), 0, 0, 0);
    chk("R4 no dispatch", desc_valid, 0);
    bus_rd(12'h044, v); chk("R4 status", v, 32'hC001);
    bus_rd(12'h110, v); chk("R4 ist", v, 32'h00C0_0000);
    chk("R9 irq disabled", irq, 0);
    bus_wr(12'h114, 32'h0080_0000);
    chk("R9 no global", irq, 0);
    bus_wr(12'h114, 32'h8080_0000);
    chk("R9 enabled", irq, 1);
    bus_wr(12'h110, 32'h0040_0000);
    bus_rd(12'h110, v); chk("R8 partial clear", v, 32'h0080_0000);
    bus_wr(12'h110, 32'h0080_0000);
    chk("R9 cleared", irq, 0);
    bus_wr(12'h114, 32'h80E0_0000);

    // Random commands
    for (int i = 0; i < 60; i++) begin
      int kind;
      logic [7:0] op, a5, a0;
      logic [31:0] a14, n;
      logic [2:0] nab, hb, db;
      logic [1:0] cl, al, dl;
      logic [5:0] dm;
      logic dir, req;
      logic [3:0] e;
      logic [31:0] ist;
      kind = $urandom % 3;
      op = 8'($urandom); a0 = 8'($urandom); a5 = 8'($urandom); a14 = $urandom;
      nab = 3'($urandom); hb = 3'($urandom); db = 3'($urandom);
      cl = 2'($urandom); al = 2'($urandom); dl = 2'($urandom);
      dm = 6'($urandom); dir = 1'($urandom); req = 1'($urandom);
      n = (i == 7) ? 32'hFFFF_FFFF : $urandom;
      e = (($urandom % 3) == 0) ? 4'($urandom) : 4'd0;
      if (kind == 2) begin
        send({31'd0, req}, e_w1(7'd127, 8'd0), e_dw2(n), e_dw3(n, dm), e_dw4(db, dl, dir));
        chk("R4 orphan no dispatch", desc_valid, 0);
        bus_rd(12'h044, v); chk("R4 orphan status", v, 32'hC001);
        ist = 32'h0040_0000 | (req ? 32'h0080_0000 : 0);
      end else begin
        if (kind == 0) begin
          send({31'd0, req}, e_w1(0, a0), a14, e_hw3(nab, op, a5), e_hw4(hb, cl, al));
        end else begin
          send(0, e_w1(1, a0), a14, e_hw3(nab, op, a5), e_hw4(hb, cl, al));
          chk("R3 header waits", desc_valid, 0);
          send({31'd0, req}, e_w1(7'd127, 8'd0), e_dw2(n), e_dw3(n, dm), e_dw4(db, dl, dir));
        end
        chk("R2 valid", desc_valid, 1);
        chk("R2 opcode", desc_opcode, op);
        chk("R2 addr", desc_addr, {a5, a14, a0});
        chk("R2 fields", {desc_addr_nbytes, desc_cmd_lanes, desc_addr_lanes}, {nab, cl, al});
        chk("R3 has_data", desc_has_data, kind == 1);
        chk("R3 bank", desc_bank, (kind == 1) ? db : hb);
        if (kind == 1)
          chk("R3 data fields", {desc_nbytes, desc_dummy, desc_data_lanes, desc_dir}, {n, dm, dl, dir});
        else
          chk("R2 data fields zero", {desc_nbytes, desc_dummy, desc_data_lanes, desc_dir}, 0);
        bus_rd(12'h044, v); chk("R6 status cleared", v, 0);
        finish_cmd(e);
        chk("R5 valid drop", desc_valid, 0);
        bus_rd(12'h100, v); chk("R5 busy clear", v, 0);
        bus_rd(12'h044, v); chk("R5 status", v, exp_status(e));
        ist = ((kind == 1) ? 32'h0020_0000 : 0) | (req ? 32'h0080_0000 : 0)
            | ((e != 0) ? 32'h0040_0000 : 0);
      end
      bus_rd(12'h110, v); chk("R8 ist", v, ist);
      chk("R9 irq", irq, ist != 0);
      bus_wr(12'h110, ist);
      bus_rd(12'h110, v); chk("R8 w1c", v, 0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule